// File: doc/BRIEF.md
# Parallel NOR Flash Write-Cycle Sequencer

This block sits between a host request port and an asynchronous parallel NOR flash device. It runs from one system clock and turns each accepted host request into a timed strobe sequence on the flash pins. A read request produces a single read strobe. A write request produces a write pulse and then a wait on the device's ready/busy pin. After that wait the block polls the status register and returns the result to the host. Every interval is given in nanoseconds as a parameter. Each one becomes a clock count by rounding the division by the clock period up, with a floor of one cycle.

The write pulse ends on the rising edge of the write-enable line. Chip enable is held low for the whole pulse, so the effective pulse equals the write-enable low time. After reset the block releases the device reset line and then waits out a recovery interval set by the device density. The program-enable line goes high with the first write pulse. It stays high until a status poll reports no error bits. The block refuses new requests during reset recovery, strobe activity, the busy wait and the status poll.

Top module: `flash_wr_seq`

## Requirements
- R1: While `rst_n` is low, `fl_rp_n` is 0, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, `fl_vpen` and `fl_dq_oe` are 0. `fl_rp_n` rises on the first clock edge after reset is released. The first strobe falls no earlier than the recovery count after that edge. The recovery is 150, 180 or 210 ns for a DENSITY_MBIT of 32, 64 or 128.
- R2: A write holds `fl_we_n` low for exactly max(ceil(60/T), ceil(55/T), ceil(50/T)) cycles, where T is the clock period in ns. Across the whole pulse, `fl_ce_n` is low, `fl_dq_oe` and `fl_vpen` are high, and `fl_addr` and `fl_dq_out` stay stable at the request's address and data.
- R3: Between the rise of any strobe (write or read enable) and the next strobe fall, both strobes stay high for more than max(ceil(30/T), ceil(35/T)) cycles.
- R4: After a write pulse ends, the status-register read strobe falls no earlier than ceil(500/T)+1 cycles later. It falls only after `fl_sts` has been sampled low and then high, on the first cycle where both conditions hold.
- R5: If the poll cannot start within TMO_CYC+1 cycles of the write pulse's end, the block pulses `rsp_valid` with `rsp_timeout` = 1 at exactly that cycle. No read strobe is issued.
- R6: A status poll holds `fl_oe_n` and `fl_ce_n` low for ceil(T_RD_NS/T) cycles. It returns the sampled word on `rsp_rdata` and returns `rsp_err` = {bit5, bit4, bit3, bit1} of that word, with bit5 in position 3.
- R7: `fl_vpen` falls only when a status poll completes with `rsp_err` equal to 0. After a poll with error bits, or after a timeout, it stays high.
- R8: A host read holds `fl_oe_n` and `fl_ce_n` low for ceil(T_RD_NS/T) cycles. It returns the data sampled at the end of the strobe with `rsp_err` = 0 and `rsp_timeout` = 0, whatever that data's bits 5, 4, 3 and 1 are.
- R9: `req_ready` is 0 during reset recovery and from request acceptance until the response. Each accepted request produces exactly one single-cycle `rsp_valid`.
- R10: `fl_we_n` and `fl_oe_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Flash word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW | Read data, or status word after a write |
| rsp_err | output | 4 | Status error bits {5,4,3,1} of a poll |
| rsp_timeout | output | 1 | Ready/busy handshake not seen in time |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Data driven toward the flash |
| fl_dq_oe | output | 1 | Data output enable |
| fl_dq_in | input | DW | Data returned by the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output (read) enable, active low |
| fl_rp_n | output | 1 | Device reset, active low |
| fl_vpen | output | 1 | Program-enable supply control |
| fl_sts | input | 1 | Ready/busy pin, low = busy |

## Verification
The in-module assertions check, on every cycle, the lower bounds of the timing rules. These are the reset recovery before any strobe, the minimum write-pulse width, the quiet gap between strobes, and the wait after a write before the poll. On every cycle they also check that the pulse qualifiers and the address and data stay steady, that the two strobes never overlap, and that the program-enable line drops only on a clean poll. Some behaviour only the bench's scenarios can show. This covers the exact cycle of the poll for short and long busy pulses, the timeout cycle when the pin never goes busy, and the decoding of the status error bits. It also covers plain reads ignoring those bits and the program-enable line staying high across error and timeout writes.

// File: rtl/flash_wr_seq.sv
module flash_wr_seq #(
  parameter int CLK_NS       = 4,
  parameter int DENSITY_MBIT = 32,
  parameter int AW           = 24,
  parameter int DW           = 16,
  parameter int T_WP_NS      = 60,
  parameter int T_AS_NS      = 55,
  parameter int T_DS_NS      = 50,
  parameter int T_WPH_NS     = 30,
  parameter int T_WRR_NS     = 35,
  parameter int T_STS_NS     = 500,
  parameter int T_RD_NS      = 75,
  parameter int TMO_CYC      = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [3:0]    rsp_err,
  output logic          rsp_timeout,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          fl_rp_n,
  output logic          fl_vpen,
  input  logic          fl_sts
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RPH_NS = (DENSITY_MBIT >= 128) ? 210 : (DENSITY_MBIT >= 64) ? 180 : 150;
  localparam int RPH_I  = ns2cyc(RPH_NS);
  localparam int LOW_I  = imax(ns2cyc(T_WP_NS), imax(ns2cyc(T_AS_NS), ns2cyc(T_DS_NS)));
  localparam int GAP_I  = imax(ns2cyc(T_WPH_NS), ns2cyc(T_WRR_NS));
  localparam int STS_I  = imax(ns2cyc(T_STS_NS), GAP_I);
  localparam int RD_I   = ns2cyc(T_RD_NS);
  localparam int CW     = $clog2(TMO_CYC + STS_I + RPH_I + LOW_I + RD_I + 2) + 1;

  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] RPH_C = CW'(RPH_I);
  localparam logic [CW-1:0] LOW_C = CW'(LOW_I);
  localparam logic [CW-1:0] GAP_C = CW'(GAP_I);
  localparam logic [CW-1:0] STS_C = CW'(STS_I);
  localparam logic [CW-1:0] RD_C  = CW'(RD_I);
  localparam logic [CW-1:0] TMO_C = CW'(TMO_CYC);

  typedef enum logic [2:0] {RECOV, IDLE, WLOW, STSW, RDLOW} st_t;

  st_t           st;
  logic [CW-1:0] cnt, gap;
  logic          busy_seen, poll;
  logic [3:0]    sr_err;

  assign req_ready = (st == IDLE) && (gap == '0);
  assign sr_err    = {fl_dq_in[5], fl_dq_in[4], fl_dq_in[3], fl_dq_in[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RECOV;  cnt <= RPH_C;  gap <= '0;
      busy_seen <= 1'b0;  poll <= 1'b0;
      fl_addr <= '0;  fl_dq_out <= '0;  fl_dq_oe <= 1'b0;
      fl_ce_n <= 1'b1;  fl_we_n <= 1'b1;  fl_oe_n <= 1'b1;
      fl_rp_n <= 1'b0;  fl_vpen <= 1'b0;
      rsp_valid <= 1'b0;  rsp_rdata <= '0;  rsp_err <= '0;  rsp_timeout <= 1'b0;
    end else begin
      fl_rp_n   <= 1'b1;
      rsp_valid <= 1'b0;
      if (gap != '0) gap <= gap - 1'b1;
      case (st)
        RECOV: if (cnt <= ONE) st <= IDLE; else cnt <= cnt - 1'b1;
        IDLE: if (req_valid && req_ready) begin
          fl_addr <= req_addr;
          fl_ce_n <= 1'b0;
          poll    <= 1'b0;
          if (req_write) begin
            fl_we_n <= 1'b0;  fl_dq_oe <= 1'b1;  fl_dq_out <= req_wdata;  fl_vpen <= 1'b1;
            cnt <= LOW_C;  st <= WLOW;
          end else begin
            fl_oe_n <= 1'b0;  cnt <= RD_C;  st <= RDLOW;
          end
        end
        WLOW: if (cnt <= ONE) begin
          fl_we_n <= 1'b1;  fl_ce_n <= 1'b1;  fl_dq_oe <= 1'b0;
          cnt <= '0;  busy_seen <= 1'b0;  gap <= GAP_C;  st <= STSW;
        end else cnt <= cnt - 1'b1;
        STSW: begin
          cnt <= cnt + 1'b1;
          if (!fl_sts) busy_seen <= 1'b1;
          if (cnt >= STS_C && busy_seen && fl_sts) begin
            fl_ce_n <= 1'b0;  fl_oe_n <= 1'b0;  poll <= 1'b1;  cnt <= RD_C;  st <= RDLOW;
          end else if (cnt >= TMO_C) begin
            rsp_valid <= 1'b1;  rsp_timeout <= 1'b1;  rsp_err <= '0;  rsp_rdata <= '0;
            st <= IDLE;
          end
        end
        RDLOW: if (cnt <= ONE) begin
          fl_oe_n <= 1'b1;  fl_ce_n <= 1'b1;
          rsp_valid <= 1'b1;  rsp_rdata <= fl_dq_in;  rsp_timeout <= 1'b0;
          rsp_err <= poll ? sr_err : 4'b0;
          if (poll && sr_err == 4'b0) fl_vpen <= 1'b0;
          gap <= GAP_C;  st <= IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  logic [CW-1:0] a_rp, a_wlo, a_hi, a_wend;
  logic          strobe_idle;
  assign strobe_idle = fl_we_n && fl_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rp <= '0;  a_wlo <= '0;  a_hi <= '1;  a_wend <= '0;
    end else begin
      if (fl_rp_n && a_rp != '1) a_rp <= a_rp + 1'b1;
      a_wlo <= fl_we_n ? '0 : a_wlo + 1'b1;
      if (!strobe_idle) a_hi <= '0; else if (a_hi != '1) a_hi <= a_hi + 1'b1;
      if (!fl_we_n) a_wend <= '0; else if (a_wend != '1) a_wend <= a_wend + 1'b1;
    end
  end

  assert_rp_recovery_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_we_n) || $fell(fl_oe_n)) |-> a_rp >= RPH_C) else $error("reset recovery short");
  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> a_wlo >= LOW_C) else $error("write pulse short");
  assert_pulse_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_dq_oe && fl_vpen)) else $error("pulse qualifiers");
  assert_pulse_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out))) else $error("addr/data moved");
  assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_idle) |-> a_hi >= GAP_C) else $error("strobe gap short");
  assert_sts_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_oe_n) && poll) |-> a_wend > STS_C) else $error("poll too early");
  assert_tmo_nopoll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_timeout) |-> (fl_oe_n && fl_vpen)) else $error("timeout state");
  assert_vpen_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_vpen) |-> ($rose(fl_oe_n) && rsp_valid && rsp_err == 4'b0)) else $error("vpen dropped early");
  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (strobe_idle && fl_rp_n)) else $error("ready while busy");
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)) else $error("strobes overlap");

endmodule

// File: tb/flash_wr_seq_tb.sv
`timescale 1ns/1ps
module flash_wr_seq_tb;
  localparam int RPH = 38, LOW = 15, GAP = 9, STS = 125, RD = 19, TMO = 300;

  logic clk = 1'b0, rst_n = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rd_val = '0;
  logic req_ready, rsp_valid, rsp_timeout, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, fl_rp_n, fl_vpen;
  logic fl_sts = 1'b1;
  logic [15:0] rsp_rdata, fl_dq_out;
  logic [3:0] rsp_err;
  logic [23:0] fl_addr;

  always #2 clk = ~clk;

  flash_wr_seq #(.TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(rd_val),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_rp_n(fl_rp_n),
    .fl_vpen(fl_vpen), .fl_sts(fl_sts));

  int cyc = 0, checks = 0, fails = 0, rsp_cnt = 0, req_cnt = 0;
  int t_rp = 0, t_wf = 0, t_wr = 0, t_of = 0, t_sr = 0, exp_poll = 0;
  int busy_mode = 0, busy_end = 0;
  bit first_strobe = 1, poll_pending = 0, tmo_pending = 0, rsp_seen = 0, done = 0;
  bit p_we = 1, p_oe = 1, p_rp = 0;
  logic [23:0] exp_addr;
  logic [15:0] exp_data, exp_rdata;
  logic [3:0] exp_err;
  bit exp_tmo;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // per-clock reference model and comparison
  always @(negedge clk) if (rst_n) begin
    if (!fl_we_n && !fl_oe_n) chk(0, "R10 both strobes low", 0, 1);
    if (fl_rp_n && !p_rp) t_rp = cyc;
    if ((!fl_we_n && p_we) || (!fl_oe_n && p_oe)) begin
      if (first_strobe) chk(cyc - t_rp == RPH, "R1 recovery", cyc - t_rp, RPH);
      else chk(cyc - t_sr >= GAP + 1, "R3 strobe gap", cyc - t_sr, GAP + 1);
      first_strobe = 0;
    end
    if (!fl_we_n && p_we) t_wf = cyc;
    if (!fl_we_n)
      chk(fl_addr == exp_addr && fl_dq_out == exp_data && !fl_ce_n && fl_dq_oe && fl_vpen,
          "R2 pulse qualifiers", {fl_addr, fl_dq_out}, {exp_addr, exp_data});
    if (fl_we_n && !p_we) begin
      chk(cyc - t_wf == LOW, "R2 pulse width", cyc - t_wf, LOW);
      t_wr = cyc; t_sr = cyc;
      poll_pending = (busy_mode == 1);
      tmo_pending  = (busy_mode == 0);
      exp_poll = t_wr + ((busy_end + 1 > STS + 1) ? busy_end + 1 : STS + 1);
    end
    if (!fl_oe_n && p_oe) begin
      t_of = cyc;
      if (poll_pending) chk(cyc == exp_poll, "R4 poll cycle", cyc, exp_poll);
      if (tmo_pending) chk(0, "R5 read strobe during timeout", cyc, 0);
      poll_pending = 0;
    end
    if (!fl_oe_n) chk(!fl_ce_n, "R6 ce during read", fl_ce_n, 0);
    if (fl_oe_n && !p_oe) begin
      chk(cyc - t_of == RD, "R8 read strobe width", cyc - t_of, RD);
      t_sr = cyc;
    end
    if (rsp_valid) begin
      rsp_cnt++;
      rsp_seen = 1;
      chk(rsp_timeout == exp_tmo, "R5 timeout flag", rsp_timeout, exp_tmo);
      if (exp_tmo) chk(cyc == t_wr + TMO + 1, "R5 timeout cycle", cyc, t_wr + TMO + 1);
      else begin
        chk(rsp_rdata == exp_rdata, "R6 response data", rsp_rdata, exp_rdata);
        chk(rsp_err == exp_err, "R6 error bits", rsp_err, exp_err);
      end
      tmo_pending = 0;
    end
    fl_sts = !(busy_mode == 1 && !first_strobe && cyc >= t_wr + 2 && cyc < t_wr + busy_end);
    p_we = fl_we_n; p_oe = fl_oe_n; p_rp = fl_rp_n;
  end

  task automatic do_op(input bit w, input logic [23:0] a, input logic [15:0] d);
    exp_addr = a; exp_data = d; rsp_seen = 0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_cnt++;
    chk(!req_ready, "R9 ready low while busy", req_ready, 0);
    while (!rsp_seen) @(negedge clk);
  endtask

  initial begin
    #1 rst_n = 0;
    repeat (4) @(negedge clk);
    chk(!fl_rp_n && fl_we_n && fl_oe_n && fl_ce_n && !fl_vpen && !fl_dq_oe && !req_ready,
        "R1 reset state", {fl_rp_n, fl_we_n, fl_oe_n, fl_ce_n, fl_vpen, fl_dq_oe, req_ready}, 7'b0111000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!req_ready, "R9 ready low in recovery", req_ready, 0);
    // R8 plain reads, back to back (R3)
    rd_val = 16'hA5C3; exp_rdata = 16'hA5C3; exp_err = 0; exp_tmo = 0;
    do_op(0, 24'h000100, 16'h0);
    rd_val = 16'h123A; exp_rdata = 16'h123A;
    do_op(0, 24'h000200, 16'h0);
    // R4/R7 write, short busy, clean status
    busy_mode = 1; busy_end = 20; rd_val = 16'h0080; exp_rdata = 16'h0080; exp_err = 4'b0000;
    do_op(1, 24'h00ABCD, 16'h5A5A);
    @(negedge clk); chk(!fl_vpen, "R7 vpen after clean poll", fl_vpen, 0);
    // R4/R6 write, long busy, status with bits 5 and 3
    busy_end = 200; rd_val = 16'h00A8; exp_rdata = 16'h00A8; exp_err = 4'b1010;
    do_op(1, 24'h123456, 16'hC3C3);
    @(negedge clk); chk(fl_vpen, "R7 vpen held after error", fl_vpen, 1);
    // R5 timeout: ready/busy never goes low
    busy_mode = 0; exp_tmo = 1;
    do_op(1, 24'h0F0F0F, 16'h0001);
    @(negedge clk); chk(fl_vpen, "R7 vpen held after timeout", fl_vpen, 1);
    // R8 read ignores status-like bits
    exp_tmo = 0; rd_val = 16'h00FF; exp_rdata = 16'h00FF; exp_err = 0;
    do_op(0, 24'h000003, 16'h0);
    @(negedge clk); chk(fl_vpen, "R8 read leaves vpen", fl_vpen, 1);
    // R6 bit4 error, then a clean write
    busy_mode = 1; busy_end = 30; rd_val = 16'h0092; exp_rdata = 16'h0092; exp_err = 4'b0101;
    do_op(1, 24'h000777, 16'hBEEF);
    rd_val = 16'h0080; exp_rdata = 16'h0080; exp_err = 4'b0000;
    do_op(1, 24'h000778, 16'hF00D);
    @(negedge clk); chk(!fl_vpen, "R7 vpen after final clean poll", fl_vpen, 0);
    repeat (5) @(negedge clk);
    chk(rsp_cnt == req_cnt, "R9 one response per request", rsp_cnt, req_cnt);
    done = 1;
    report;
    $finish;
  end

  always @(posedge clk) if (cyc > 150000 && !done) begin
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 150000);
    report;
    $finish;
  end
endmodule